// File: doc/BRIEF.md
# Golden-compare memory monitor

This block supervises one fault-injection experiment on a core under test that runs next to a fault-free reference core executing the same program. Each core has its own data memory. The monitor controls both memories whenever the cores are held in reset.

When an experiment is started, the monitor first writes a clear value into every location of both memories, one address per cycle. This stops corruption from a previous experiment from carrying over into the next one. It then releases both cores and raises the injection-enable window for as long as the application runs.

The run ends in one of three ways:
- The core under test reports its own end-of-application within a fixed cycle margin after the reference core does.
- That margin runs out, which is a loss of program sequence.
- An overall run limit expires, which is also a loss of program sequence.

After the run, the monitor takes back both memories and reads every address of the pair in ascending order. It compares the two read words and records whether any differed, and the lowest address that did. The outcome is reported on a done flag, a data-error flag, a lost-sequence flag and a first-mismatch address. All of these are held until the next experiment is started.

Top module: `gcm_monitor`

## Requirements
- R1: After reset, `done`, `data_err` and `lost_seq` are 0, `first_bad_addr` is 0, `core_hold` is 1, `inject_en` is 0 and `mem_own` is 1.
- R2: An accepted `start` causes exactly DEPTH clear cycles. In each of them `mem_we` is 1, `mem_wdata` carries the clear value (all zeros by default), and `mem_addr` steps from 0 up by one per cycle. Both cores stay held (`core_hold` = 1) throughout.
- R3: Right after the last clear cycle, `core_hold` falls and `inject_en` rises. `mem_own` is 0 exactly while `inject_en` is 1.
- R4: Let the reference end strobe `ref_end` be sampled in cycle t. If `dut_end` has not been seen by cycle t+MARGIN, the run ends at the close of cycle t+MARGIN and `lost_seq` becomes 1.
- R5: If `dut_end` is seen at any point of the run up to and including cycle t+MARGIN, `lost_seq` stays 0.
- R6: If the run has not otherwise resolved, it ends after exactly RUN_LIMIT cycles with `core_hold` low. In that case `lost_seq` becomes 1 and the memory scan still follows.
- R7: After the run, `mem_re` is 1 for exactly DEPTH cycles, with `mem_addr` going 0, 1, ..., DEPTH-1. `mem_we` and `mem_re` are never 1 together. `data_err` is 1 if and only if `ref_rdata` and `dut_rdata` differed for some scanned address. Read data arrives RD_LAT cycles after the address.
- R8: `first_bad_addr` holds the lowest mismatching address, and 0 when there was no mismatch.
- R9: `done` rises after the scan. `done`, `data_err`, `lost_seq` and `first_bad_addr` then keep their values until the next accepted `start`, which returns all of them to 0.
- R10: A `start` pulse while an experiment is in progress (clear, run or scan) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new experiment (accepted only when idle or done) |
| ref_end | input | 1 | End-of-application strobe from the reference core |
| dut_end | input | 1 | End-of-application strobe from the core under test |
| ref_rdata | input | DW | Read data from the reference core memory |
| dut_rdata | input | DW | Read data from the core-under-test memory |
| core_hold | output | 1 | Holds both cores in reset when 1 |
| inject_en | output | 1 | Fault-injection window, high while the application runs |
| mem_own | output | 1 | 1 when the monitor drives the memory ports, 0 when the cores do |
| mem_addr | output | AW | Address shared by both memories during clear and scan |
| mem_we | output | 1 | Write strobe for the clear pass |
| mem_wdata | output | DW | Clear value written during the clear pass |
| mem_re | output | 1 | Read strobe for the scan pass |
| done | output | 1 | Experiment finished, status valid |
| data_err | output | 1 | Some scanned location differed |
| lost_seq | output | 1 | Loss of program sequence or run timeout |
| first_bad_addr | output | AW | Lowest mismatching address |

## Verification
The assertions assume three things about the memories:
- They are synchronous with a fixed read latency of RD_LAT cycles.
- Nothing but the monitor writes them while `mem_own` is 1.
- The end strobes only matter while `inject_en` is high.

The bench models both memories with one-cycle read latency. It writes the application data only during the run window, and drives the end strobes only while the cores are released. Every mismatch position across a small memory is swept, and the margin is probed at its exact edge and one cycle past it.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CLEAR = 3'd1,
      ST_RUN   = 3'd2,
      ST_SCAN  = 3'd3,
      ST_DONE  = 3'd4
   } gcm_state_e;
endpackage

// File: rtl/gcm_addr_seq.sv
// Address sequencer shared by the clear pass and the scan pass.
module gcm_addr_seq #(
   parameter int DEPTH = 256,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (restart) addr <= '0;
      else if (step)    addr <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
   end

   assign last = (addr == LAST_ADDR);
endmodule

// File: rtl/gcm_run_watch.sv
// Watches the end strobes during the run window and decides when the
// run is over and whether the program sequence was lost.
module gcm_run_watch #(
   parameter int MARGIN    = 16,
   parameter int RUN_LIMIT = 100000,
   localparam int MW = $clog2(MARGIN + 1),
   localparam int RW = $clog2(RUN_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ref_end,
   input  logic dut_end,
   output logic finish,
   output logic lost
);
   logic          waiting;
   logic          dut_seen;
   logic [MW-1:0] mcnt;
   logic [RW-1:0] rcnt;
   logic          dut_now, ok_now, margin_out, tmo;

   always_comb begin
      dut_now    = dut_seen | dut_end;
      ok_now     = waiting & dut_now;
      margin_out = waiting & ~dut_now & (mcnt == MW'(MARGIN - 1));
      tmo        = (rcnt == RW'(RUN_LIMIT - 1));
      finish     = active & (ok_now | margin_out | tmo);
      lost       = active & ~ok_now & (margin_out | tmo);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting  <= 1'b0;
         dut_seen <= 1'b0;
         mcnt     <= '0;
         rcnt     <= '0;
      end else if (!active || finish) begin
         waiting  <= 1'b0;
         dut_seen <= 1'b0;
         mcnt     <= '0;
         rcnt     <= '0;
      end else begin
         rcnt <= rcnt + 1'b1;
         if (dut_end) dut_seen <= 1'b1;
         if (!waiting) begin
            if (ref_end) begin
               waiting <= 1'b1;
               mcnt    <= '0;
            end
         end else begin
            mcnt <= mcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gcm_cmp.sv
// Compare pipeline: carries the issued address alongside the memory read
// latency and flags a mismatch when the two read words arrive.
module gcm_cmp #(
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter int RD_LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [AW-1:0] issue_addr,
   input  logic [DW-1:0] ref_rdata,
   input  logic [DW-1:0] dut_rdata,
   output logic          res_valid,
   output logic          res_bad,
   output logic [AW-1:0] res_addr,
   output logic          busy
);
   logic [RD_LAT-1:0] vld;
   logic [AW-1:0]     adr [RD_LAT];

   for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[0] <= 1'b0;
               adr[0] <= '0;
            end else begin
               vld[0] <= issue;
               adr[0] <= issue_addr;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[g] <= 1'b0;
               adr[g] <= '0;
            end else begin
               vld[g] <= vld[g-1];
               adr[g] <= adr[g-1];
            end
         end
      end
   end

   assign res_valid = vld[RD_LAT-1];
   assign res_addr  = adr[RD_LAT-1];
   assign res_bad   = res_valid && (ref_rdata != dut_rdata);
   assign busy      = |vld;
endmodule

// File: rtl/gcm_monitor.sv
module gcm_monitor #(
   parameter int DEPTH     = 256,
   parameter int DW        = 8,
   parameter int MARGIN    = 16,
   parameter int RUN_LIMIT = 100000,
   parameter int RD_LAT    = 1,
   parameter logic [DW-1:0] CLR_VAL = '0,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ref_end,
   input  logic          dut_end,
   input  logic [DW-1:0] ref_rdata,
   input  logic [DW-1:0] dut_rdata,
   output logic          core_hold,
   output logic          inject_en,
   output logic          mem_own,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_re,
   output logic          done,
   output logic          data_err,
   output logic          lost_seq,
   output logic [AW-1:0] first_bad_addr
);
   import gcm_pkg::*;

   if (DEPTH < 2)         begin : g_bad_depth  $error("DEPTH must be at least 2");        end
   if (DW < 1)            begin : g_bad_dw     $error("DW must be at least 1");           end
   if (MARGIN < 1)        begin : g_bad_margin $error("MARGIN must be at least 1");       end
   if (RUN_LIMIT < 2)     begin : g_bad_limit  $error("RUN_LIMIT must be at least 2");    end
   if (RD_LAT < 1)        begin : g_bad_lat    $error("RD_LAT must be at least 1");       end

   gcm_state_e    state_q, state_d;
   logic          acc_start;
   logic          addr_last, addr_step, addr_restart;
   logic          issue, issued_all;
   logic          run_finish, run_lost;
   logic          res_valid, res_bad, busy;
   logic [AW-1:0] res_addr;
   logic [AW-1:0] addr;

   assign acc_start = start && (state_q == ST_IDLE || state_q == ST_DONE);
   assign issue     = (state_q == ST_SCAN) && !issued_all;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE, ST_DONE: if (acc_start) state_d = ST_CLEAR;
         ST_CLEAR:         if (addr_last) state_d = ST_RUN;
         ST_RUN:           if (run_finish) state_d = ST_SCAN;
         ST_SCAN:          if (issued_all && !busy) state_d = ST_DONE;
         default:          state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign addr_restart = acc_start || run_finish;
   assign addr_step    = (state_q == ST_CLEAR) || issue;

   gcm_addr_seq #(.DEPTH(DEPTH)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (addr_restart),
      .step    (addr_step),
      .addr    (addr),
      .last    (addr_last)
   );

   gcm_run_watch #(.MARGIN(MARGIN), .RUN_LIMIT(RUN_LIMIT)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (state_q == ST_RUN),
      .ref_end (ref_end),
      .dut_end (dut_end),
      .finish  (run_finish),
      .lost    (run_lost)
   );

   gcm_cmp #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_addr (addr),
      .ref_rdata  (ref_rdata),
      .dut_rdata  (dut_rdata),
      .res_valid  (res_valid),
      .res_bad    (res_bad),
      .res_addr   (res_addr),
      .busy       (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     issued_all <= 1'b0;
      else if (addr_restart)          issued_all <= 1'b0;
      else if (issue && addr_last)    issued_all <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done           <= 1'b0;
         data_err       <= 1'b0;
         lost_seq       <= 1'b0;
         first_bad_addr <= '0;
      end else if (acc_start) begin
         done           <= 1'b0;
         data_err       <= 1'b0;
         lost_seq       <= 1'b0;
         first_bad_addr <= '0;
      end else begin
         if (state_q == ST_RUN && run_finish) lost_seq <= run_lost;
         if (res_valid && res_bad && !data_err) begin
            data_err       <= 1'b1;
            first_bad_addr <= res_addr;
         end
         if (state_q == ST_SCAN && state_d == ST_DONE) done <= 1'b1;
      end
   end

   assign core_hold = (state_q != ST_RUN);
   assign inject_en = (state_q == ST_RUN);
   assign mem_own   = (state_q != ST_RUN);
   assign mem_addr  = addr;
   assign mem_we    = (state_q == ST_CLEAR);
   assign mem_wdata = CLR_VAL;
   assign mem_re    = issue;
endmodule

// File: rtl/gcm_monitor_chk.sv
module gcm_monitor_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          core_hold,
   input logic          inject_en,
   input logic          mem_own,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_re,
   input logic          done,
   input logic          data_err,
   input logic          lost_seq,
   input logic [AW-1:0] first_bad_addr
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_hold_in_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> core_hold);

   assert_clear_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   assert_port_handoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inject_en |-> (!mem_own && !core_hold));

   assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   assert_clean_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !data_err |-> (first_bad_addr == '0));

   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && done && $past(done)) |->
         ($stable(data_err) && $stable(lost_seq) && $stable(first_bad_addr)));
endmodule

bind gcm_monitor gcm_monitor_chk #(.AW(AW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .core_hold      (core_hold),
   .inject_en      (inject_en),
   .mem_own        (mem_own),
   .mem_addr       (mem_addr),
   .mem_we         (mem_we),
   .mem_re         (mem_re),
   .done           (done),
   .data_err       (data_err),
   .lost_seq       (lost_seq),
   .first_bad_addr (first_bad_addr)
);

// File: tb/gcm_monitor_tb.sv
module gcm_monitor_tb;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int MG    = 4;
   localparam int LIM   = 64;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, ref_end = 1'b0, dut_end = 1'b0;
   logic [DW-1:0] ref_rdata, dut_rdata;
   logic core_hold, inject_en, mem_own, mem_we, mem_re;
   logic done, data_err, lost_seq;
   logic [AW-1:0] mem_addr, first_bad_addr;
   logic [DW-1:0] mem_wdata;

   logic [DW-1:0] ref_m [DEPTH];
   logic [DW-1:0] dut_m [DEPTH];

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   gcm_monitor #(.DEPTH(DEPTH), .DW(DW), .MARGIN(MG), .RUN_LIMIT(LIM), .RD_LAT(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_end(ref_end), .dut_end(dut_end),
      .ref_rdata(ref_rdata), .dut_rdata(dut_rdata), .core_hold(core_hold),
      .inject_en(inject_en), .mem_own(mem_own), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_re(mem_re), .done(done), .data_err(data_err),
      .lost_seq(lost_seq), .first_bad_addr(first_bad_addr));

   always @(posedge clk) begin
      if (mem_own && mem_we) begin
         ref_m[mem_addr] <= mem_wdata;
         dut_m[mem_addr] <= mem_wdata;
      end
      if (mem_re) begin
         ref_rdata <= ref_m[mem_addr];
         dut_rdata <= dut_m[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ref_t/dut_t: run-cycle index of each strobe, -1 for never.
   task automatic run_case(input int b0, input int b1, input int ref_t, input int dut_t,
                           input bit exp_lost, input int exp_runlen);
      int wecnt, runcnt, rdcnt, zero_ok, guard, first_exp;
      logic s_err, s_lost;
      logic [AW-1:0] s_first;
      for (int i = 0; i < DEPTH; i++) begin
         ref_m[i] = DW'(8'h5A + i);
         dut_m[i] = DW'(8'hC3 ^ i);
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0 && data_err == 1'b0 && lost_seq == 1'b0, "R9 start clears status",
          {done, data_err, lost_seq}, 0);
      wecnt = 0; guard = 0;
      while (core_hold && guard < 1000) begin
         if (mem_we) wecnt++;
         guard++;
         @(negedge clk);
      end
      chk(wecnt == DEPTH, "R2 clear cycles", wecnt, DEPTH);
      zero_ok = 1;
      for (int i = 0; i < DEPTH; i++)
         if (ref_m[i] != '0 || dut_m[i] != '0) zero_ok = 0;
      chk(zero_ok == 1, "R2 memories cleared", zero_ok, 1);
      chk(inject_en == 1'b1 && mem_own == 1'b0, "R3 run window open", {inject_en, mem_own}, 2);
      for (int i = 0; i < DEPTH; i++) begin
         ref_m[i] = DW'(i * 7 + 3);
         dut_m[i] = DW'(i * 7 + 3);
      end
      if (b0 >= 0) dut_m[b0] = dut_m[b0] ^ 8'h10;
      if (b1 >= 0) dut_m[b1] = dut_m[b1] ^ 8'h01;
      runcnt = 0;
      for (int k = 0; k < 1000; k++) begin
         if (core_hold) break;
         if (k == 2) chk(core_hold == 1'b0, "R10 start ignored while running", core_hold, 0);
         runcnt++;
         start   = (k == 1);
         ref_end = (k == ref_t);
         dut_end = (k == dut_t);
         @(negedge clk);
      end
      start = 1'b0; ref_end = 1'b0; dut_end = 1'b0;
      if (exp_runlen > 0) chk(runcnt == exp_runlen, "R4/R6 run length", runcnt, exp_runlen);
      rdcnt = 0; guard = 0;
      while (!done && guard < 1000) begin
         if (mem_re) begin
            chk(int'(mem_addr) == rdcnt, "R7 scan order", mem_addr, rdcnt);
            rdcnt++;
         end
         guard++;
         @(negedge clk);
      end
      chk(rdcnt == DEPTH, "R7 scan reads", rdcnt, DEPTH);
      chk(lost_seq == exp_lost, exp_lost ? "R4 lost sequence" : "R5 sequence kept",
          lost_seq, exp_lost);
      chk(data_err == (b0 >= 0), "R7 data error flag", data_err, b0 >= 0);
      first_exp = 0;
      if (b0 >= 0) first_exp = (b1 >= 0 && b1 < b0) ? b1 : b0;
      chk(int'(first_bad_addr) == first_exp, "R8 first mismatch", first_bad_addr, first_exp);
      s_err = data_err; s_lost = lost_seq; s_first = first_bad_addr;
      repeat (8) @(negedge clk);
      chk(done && data_err == s_err && lost_seq == s_lost && first_bad_addr == s_first,
          "R9 status held", {done, data_err, lost_seq}, {1'b1, s_err, s_lost});
   endtask

   initial begin
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!done && !data_err && !lost_seq && first_bad_addr == '0, "R1 reset status",
          {done, data_err, lost_seq}, 0);
      chk(core_hold && !inject_en && mem_own, "R1 reset control",
          {core_hold, inject_en, mem_own}, 5);
      rst_n = 1'b1;
      @(negedge clk);
      // R5: matched ends, clean memory
      run_case(-1, -1, 5, 5, 1'b0, 0);
      // R7 R8: every mismatch position, with a second one elsewhere
      for (int a = 0; a < DEPTH; a++)
         run_case(a, (a + 5) % DEPTH, 3, 4, 1'b0, 0);
      // R5: core-under-test end at the last cycle of the margin
      run_case(-1, -1, 4, 4 + MG, 1'b0, 0);
      // R4: one cycle past the margin
      run_case(-1, -1, 4, 4 + MG + 1, 1'b1, 4 + MG + 1);
      // R5: core-under-test ends before the reference
      run_case(-1, -1, 6, 3, 1'b0, 0);
      // R6: nothing ends, timeout with a mismatch still scanned
      run_case(7, -1, -1, -1, 1'b1, LIM);
      // R6: only the core under test ends
      run_case(-1, -1, -1, 5, 1'b1, LIM);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule